// File: doc/BRIEF.md
# Strap-Addressed I2C Register Slave

This block is the serial front end of a register-mapped peripheral. It watches the open-drain SCL and SDA lines of an I2C-compatible bus, sampling them with a faster system clock. It answers only when the master calls its own 7-bit address. That address is built from two three-level strap inputs, which arrive already decoded as high, low or floating. The only output to the bus is an active-high enable that pulls SDA low. The block never drives the line high.

A write transaction sends the address with the direction bit clear, then one byte that loads an 8-bit register pointer. Any further bytes go out on a register-file write port at the pointer, and the pointer steps after each one. A read transaction sends the address with the direction bit set. It returns bytes from the register-file read port at the pointer loaded by an earlier, separate write. The pointer steps after each byte the master acknowledges. A master that declines a byte ends the read. The pointer survives between transactions and is cleared only by reset.

Top module: `i2c_strap_slave`

## Requirements
- R1: The slave address is binary 010 followed by a 4-bit low part. The low part is two 2-bit fields: the upper field comes from strap_hi_i and the lower field from strap_lo_i. Each strap maps high to 00, floating to 10 and low to 11. Strap codes on the ports are 2'b01 high, 2'b00 low, 2'b10 floating, and 2'b11 is also taken as floating. The slave pulls SDA low in the acknowledge slot of an address byte that matches.
- R2: After an address byte that does not match, the slave neither acknowledges nor pulls SDA low, and it writes nothing, until the next start or stop.
- R3: In a write transaction, the byte after the address is acknowledged and loaded as the pointer. The pointer is visible on reg_addr_o.
- R4: Each later byte of a write transaction is acknowledged and issued as a one-cycle reg_wr_o pulse, with reg_wdata_o equal to the byte and reg_addr_o equal to the pointer. The pointer then increases by one, wrapping from 255 to 0.
- R5: In a read transaction, each byte is shifted out MSB first from reg_rdata_i at the current pointer. The pointer increases by one after every byte the master acknowledges.
- R6: When the master does not acknowledge a read byte, the slave releases SDA and leaves it released until the next start. The pointer does not step for that byte.
- R7: A repeated start, with no stop before it, restarts address matching.
- R8: A stop returns the slave to idle with SDA released. The pointer is kept across transactions.
- R9: Reset releases SDA, holds reg_wr_o low and clears the pointer to 0.
- R10: The slave changes its SDA pull only while SCL is low.
- R11: Both lines pass a synchronizer and a filter that needs two agreeing samples, so an SCL pulse one system clock wide is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_hi_i | input | 2 | Decoded state of the upper address strap |
| strap_lo_i | input | 2 | Decoded state of the lower address strap |
| reg_addr_o | output | 8 | Register pointer, used for both reads and writes |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data at reg_addr_o |

## Verification
Most internal faults show up at the ports within one byte time. A bit counter or shift register that is out of step moves the acknowledge slot, so the master sees a missing acknowledge on the next byte. A wrong pointer shows on reg_addr_o as soon as the stop arrives, and it shows again in the bytes the next read returns. A wrong state after a refused address or a master NACK shows as SDA pulled low in slots the bench samples. The bench watches every cycle of SCL high for any change in the SDA pull.

// File: rtl/i2c_ss_pkg.sv
package i2c_ss_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RX   = 3'd1,
        ST_RACK = 3'd2,
        ST_TX   = 3'd3,
        ST_TACK = 3'd4
    } state_t;

    typedef enum logic [1:0] {
        K_ADDR = 2'd0,
        K_PTR  = 2'd1,
        K_DATA = 2'd2
    } kind_t;

    // strap codes on the ports: 01 high, 00 low, 10 or 11 floating
    function automatic logic [1:0] strap_field(input logic [1:0] code);
        logic [1:0] f;
        case (code)
            2'b01:   f = 2'b00;
            2'b00:   f = 2'b11;
            default: f = 2'b10;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/i2c_ss_filter.sv
module i2c_ss_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic level_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_d, sync_q;
    logic                   hist_d, hist_q;
    logic                   lvl_d, lvl_q;

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], line_i};
        hist_d = sync_q[LAST];
        lvl_d  = lvl_q;
        if (sync_q[LAST] == hist_q) begin
            lvl_d = hist_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            hist_q <= 1'b1;
            lvl_q  <= 1'b1;
        end else begin
            sync_q <= sync_d;
            hist_q <= hist_d;
            lvl_q  <= lvl_d;
        end
    end

    assign level_o = lvl_q;

    // R11: the filtered level moves only after two equal synchronized samples
    p_level_agree_r11: assert property (@(posedge clk) disable iff (rst)
        !$stable(lvl_q) |-> ($past(sync_q[LAST], 1) == $past(sync_q[LAST], 2)));

endmodule

// File: rtl/i2c_ss_cond.sv
module i2c_ss_cond (
    input  logic clk,
    input  logic rst,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_prev_d, scl_prev_q;
    logic sda_prev_d, sda_prev_q;

    always_comb begin
        scl_prev_d = scl_f;
        sda_prev_d = sda_f;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_rise  = scl_f & ~scl_prev_q;
    assign scl_fall  = ~scl_f & scl_prev_q;
    assign bus_start = scl_f & scl_prev_q & sda_prev_q & ~sda_f;
    assign bus_stop  = scl_f & scl_prev_q & ~sda_prev_q & sda_f;

    // R7 R8: start and stop need SCL high on both sampled cycles, never with an SCL edge
    p_cond_no_edge_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_start || bus_stop) |-> !(scl_rise || scl_fall));

endmodule

// File: rtl/i2c_ss_addr.sv
module i2c_ss_addr #(
    parameter logic [2:0] ADDR_HI = 3'b010
) (
    input  logic [1:0] strap_hi_i,
    input  logic [1:0] strap_lo_i,
    output logic [6:0] addr_o
);
    import i2c_ss_pkg::*;

    always_comb begin
        addr_o = {ADDR_HI, strap_field(strap_hi_i), strap_field(strap_lo_i)};
    end

endmodule

// File: rtl/i2c_strap_slave.sv
module i2c_strap_slave #(
    parameter int         SYNC_STAGES = 2,
    parameter logic [2:0] ADDR_HI     = 3'b010
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    input  logic [1:0] strap_hi_i,
    input  logic [1:0] strap_lo_i,
    output logic [7:0] reg_addr_o,
    output logic       reg_wr_o,
    output logic [7:0] reg_wdata_o,
    input  logic [7:0] reg_rdata_i
);
    import i2c_ss_pkg::*;

    localparam int          NLINES   = 2;
    localparam int          CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] BITS_DONE = CNT_W'(BYTE_W);

    typedef struct packed {
        state_t             st;
        kind_t              kind;
        logic               rd;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic [BYTE_W-1:0]  ptr;
        logic               pull;
        logic               wr;
        logic [BYTE_W-1:0]  wdata;
    } regs_t;

    localparam regs_t RESET_VAL = '{st: ST_IDLE, kind: K_ADDR, rd: 1'b0,
                                    cnt: '0, sh: '0, ptr: '0, pull: 1'b0,
                                    wr: 1'b0, wdata: '0};

    // line conditioning, one filter per bus line
    logic [NLINES-1:0] raw_lines, filt_lines;
    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        i2c_ss_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
            .clk     (clk),
            .rst     (rst),
            .line_i  (raw_lines[g]),
            .level_o (filt_lines[g])
        );
    end

    logic scl_f, sda_f;
    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    logic scl_rise, scl_fall, bus_start, bus_stop;

    i2c_ss_cond u_cond (
        .clk       (clk),
        .rst       (rst),
        .scl_f     (scl_f),
        .sda_f     (sda_f),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    logic [6:0] own_addr;

    i2c_ss_addr #(.ADDR_HI(ADDR_HI)) u_addr (
        .strap_hi_i (strap_hi_i),
        .strap_lo_i (strap_lo_i),
        .addr_o     (own_addr)
    );

    regs_t d, q;

    always_comb begin
        d    = q;
        d.wr = 1'b0;
        if (q.wr) begin
            d.ptr = q.ptr + 1'b1;
        end
        if (bus_stop) begin
            d.st   = ST_IDLE;
            d.pull = 1'b0;
        end else if (bus_start) begin
            d.st   = ST_RX;
            d.kind = K_ADDR;
            d.rd   = 1'b0;
            d.cnt  = '0;
            d.pull = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise && q.cnt != BITS_DONE) begin
                        d.sh  = {q.sh[BYTE_W-2:0], sda_f};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == BITS_DONE) begin
                        case (q.kind)
                            K_ADDR: begin
                                if (q.sh[BYTE_W-1:1] == own_addr) begin
                                    d.pull = 1'b1;
                                    d.st   = ST_RACK;
                                    d.rd   = q.sh[0];
                                    d.kind = K_PTR;
                                end else begin
                                    d.st = ST_IDLE;
                                end
                            end
                            K_PTR: begin
                                d.ptr  = q.sh;
                                d.pull = 1'b1;
                                d.st   = ST_RACK;
                                d.kind = K_DATA;
                            end
                            default: begin
                                d.wr    = 1'b1;
                                d.wdata = q.sh;
                                d.pull  = 1'b1;
                                d.st    = ST_RACK;
                            end
                        endcase
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rd) begin
                            d.st   = ST_TX;
                            d.sh   = reg_rdata_i;
                            d.pull = ~reg_rdata_i[BYTE_W-1];
                        end else begin
                            d.st   = ST_RX;
                            d.pull = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.cnt == BITS_DONE) begin
                            d.pull = 1'b0;
                            d.st   = ST_TACK;
                        end else begin
                            d.sh   = {q.sh[BYTE_W-2:0], 1'b0};
                            d.pull = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_TACK: begin
                    if (scl_rise) begin
                        if (sda_f) begin
                            d.st   = ST_IDLE;
                            d.pull = 1'b0;
                        end else begin
                            d.ptr = q.ptr + 1'b1;
                        end
                    end else if (scl_fall) begin
                        d.st   = ST_TX;
                        d.cnt  = '0;
                        d.sh   = reg_rdata_i;
                        d.pull = ~reg_rdata_i[BYTE_W-1];
                    end
                end
                default: begin
                    d.pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VAL;
        end else begin
            q <= d;
        end
    end

    assign sda_pull_o  = q.pull;
    assign reg_addr_o  = q.ptr;
    assign reg_wr_o    = q.wr;
    assign reg_wdata_o = q.wdata;

    // R4: the write strobe lasts one cycle
    p_wr_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        reg_wr_o |=> !reg_wr_o);

    // R4: the pointer steps right after each write strobe
    p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
        reg_wr_o |=> (reg_addr_o == $past(reg_addr_o) + 8'd1));

    // R6: a declined read byte releases SDA and ends the transaction
    p_nack_release_r6: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_TACK && scl_rise && sda_f) |=> (!sda_pull_o && q.st == ST_IDLE));

    // R8: idle never pulls the line
    p_idle_released_r8: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_IDLE) |-> !sda_pull_o);

    // R10: the pull only changes while the filtered SCL is low
    p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> !scl_f);

endmodule

// File: tb/i2c_strap_slave_test.sv
module i2c_strap_slave_test;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_low = 1'b0;
    logic [1:0] s_hi = 2'b01;
    logic [1:0] s_lo = 2'b01;
    logic       sda_pull_o, reg_wr_o;
    logic [7:0] reg_addr_o, reg_wdata_o, reg_rdata_i;
    logic       sda_line;

    logic [7:0] mem     [256];
    logic [7:0] exp_mem [256];
    int         errs = 0;
    int         checks = 0;
    int         wr_count = 0;
    int         high_changes = 0;
    logic       prev_pull = 1'b0;

    always #5 clk = ~clk;

    assign sda_line    = !(m_low || sda_pull_o);
    assign reg_rdata_i = mem[reg_addr_o];

    i2c_strap_slave uut (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (m_scl),
        .sda_i       (sda_line),
        .sda_pull_o  (sda_pull_o),
        .strap_hi_i  (s_hi),
        .strap_lo_i  (s_lo),
        .reg_addr_o  (reg_addr_o),
        .reg_wr_o    (reg_wr_o),
        .reg_wdata_o (reg_wdata_o),
        .reg_rdata_i (reg_rdata_i)
    );

    function automatic logic [7:0] seed_val(input int i);
        return 8'((i * 37) ^ 8'h5A);
    endfunction

    // register file model, and R10 monitor
    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] = seed_val(i);
        end else begin
            if (reg_wr_o) begin
                mem[reg_addr_o] = reg_wdata_o;
                wr_count++;
            end
            if (m_scl && sda_pull_o != prev_pull) high_changes++;
        end
        prev_pull = sda_pull_o;
    end

    function automatic logic [1:0] code_of(input int k);
        case (k)
            0:       return 2'b01;
            1:       return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [6:0] exp_addr(input int k);
        case (k)
            0: return 7'h20;  1: return 7'h22;  2: return 7'h23;
            3: return 7'h28;  4: return 7'h2A;  5: return 7'h2B;
            6: return 7'h2C;  7: return 7'h2E;  default: return 7'h2F;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; hq();
        m_scl = 1'b1; hq();
        m_low = 1'b1; hq();
        m_scl = 1'b0; hq();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; hq();
        m_scl = 1'b1; hq();
        m_low = 1'b0; hq(); hq();
    endtask

    task automatic clock_bit(input logic b, output logic s);
        m_low = !b; hq();
        m_scl = 1'b1; hq();
        s = sda_line; hq();
        m_scl = 1'b0; hq();
    endtask

    task automatic write_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
        clock_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic read_byte(input logic m_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            v[i] = s;
        end
        clock_bit(!m_ack, s);
    endtask

    task automatic set_ptr(input logic [6:0] a, input logic [7:0] p);
        logic ack;
        bus_start();
        write_byte({a, 1'b0}, ack);
        check(ack, "R1 address ack", ack, 1);
        write_byte(p, ack);
        check(ack, "R3 pointer ack", ack, 1);
        bus_stop();
        check(reg_addr_o == p, "R3 pointer loaded", reg_addr_o, p);
    endtask

    logic [7:0] ptr;
    logic [7:0] v;
    logic       ack;
    logic       s;
    int         zeros;
    int         base_wr;

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = seed_val(i);
        void'($urandom(32'd2024));
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(sda_pull_o == 1'b0, "R9 pull after reset", sda_pull_o, 0);
        check(reg_wr_o == 1'b0, "R9 strobe after reset", reg_wr_o, 0);
        check(reg_addr_o == 8'd0, "R9 pointer after reset", reg_addr_o, 0);

        // R1 R2: every strap combination, matching and non-matching address
        for (int k = 0; k < 9; k++) begin
            s_hi = code_of(k / 3);
            s_lo = code_of(k % 3);
            hq();
            set_ptr(exp_addr(k), 8'(k * 11 + 1));
            ptr = 8'(k * 11 + 1);
            base_wr = wr_count;
            bus_start();
            write_byte({exp_addr(k) ^ 7'h01, 1'b0}, ack);
            check(!ack, "R2 foreign address not acked", ack, 0);
            write_byte(8'h77, ack);
            check(!ack, "R2 byte after foreign address not acked", ack, 0);
            write_byte(8'h33, ack);
            check(!ack, "R2 second ignored byte", ack, 0);
            bus_stop();
            check(reg_addr_o == ptr, "R2 pointer untouched", reg_addr_o, ptr);
            check(wr_count == base_wr, "R2 no write", wr_count, base_wr);
        end

        // R1: code 11 counts as floating
        s_hi = 2'b11; s_lo = 2'b11; hq();
        set_ptr(7'h2A, 8'h40);

        // R11: a one-clock SCL blip during a transfer is ignored
        s_hi = 2'b01; s_lo = 2'b00; hq();
        bus_start();
        m_scl = 1'b1; @(negedge clk); m_scl = 1'b0;
        write_byte({7'h23, 1'b0}, ack);
        check(ack, "R11 ack despite SCL blip", ack, 1);
        write_byte(8'h9C, ack);
        check(ack, "R11 pointer ack despite blip", ack, 1);
        bus_stop();
        check(reg_addr_o == 8'h9C, "R11 pointer after blip", reg_addr_o, 8'h9C);

        // R7: foreign address, repeated start, own address
        bus_start();
        write_byte({7'h2C, 1'b0}, ack);
        check(!ack, "R7 first address refused", ack, 0);
        bus_start();
        write_byte({7'h23, 1'b0}, ack);
        check(ack, "R7 address after repeated start", ack, 1);
        write_byte(8'h15, ack);
        // R7: pointer write then repeated start into a read
        bus_start();
        write_byte({7'h23, 1'b1}, ack);
        check(ack, "R7 read address acked", ack, 1);
        read_byte(1'b0, v);
        check(v == exp_mem[8'h15], "R7 read after repeated start", v, exp_mem[8'h15]);
        bus_stop();
        check(reg_addr_o == 8'h15, "R6 no step on declined byte", reg_addr_o, 8'h15);

        // R6: after a declined byte the line stays released
        bus_start();
        write_byte({7'h23, 1'b1}, ack);
        read_byte(1'b0, v);
        zeros = 0;
        for (int i = 0; i < 9; i++) begin
            clock_bit(1'b1, s);
            if (!s) zeros++;
        end
        check(zeros == 0, "R6 line released after NACK", zeros, 0);
        bus_stop();
        check(sda_pull_o == 1'b0, "R8 released after stop", sda_pull_o, 0);

        // R4 R5 R8: random write and read bursts, wrap included
        for (int it = 0; it < 14; it++) begin
            int wl, rl, k;
            k  = int'($urandom_range(0, 8));
            s_hi = code_of(k / 3);
            s_lo = code_of(k % 3);
            ptr = (it == 0) ? 8'hFE : 8'($urandom_range(0, 255));
            wl = int'($urandom_range(0, 4));
            rl = int'($urandom_range(1, 4));
            hq();
            base_wr = wr_count;
            bus_start();
            write_byte({exp_addr(k), 1'b0}, ack);
            check(ack, "R1 random address ack", ack, 1);
            write_byte(ptr, ack);
            check(ack, "R3 random pointer ack", ack, 1);
            for (int j = 0; j < wl; j++) begin
                v = 8'($urandom_range(0, 255));
                exp_mem[8'(ptr + j)] = v;
                write_byte(v, ack);
                check(ack, "R4 data byte ack", ack, 1);
            end
            bus_stop();
            check(wr_count - base_wr == wl, "R4 strobe count", wr_count - base_wr, wl);
            check(reg_addr_o == 8'(ptr + wl), "R4 pointer after writes", reg_addr_o, 8'(ptr + wl));
            for (int j = 0; j < wl; j++)
                check(mem[8'(ptr + j)] == exp_mem[8'(ptr + j)], "R4 written byte",
                      mem[8'(ptr + j)], exp_mem[8'(ptr + j)]);
            ptr = 8'(ptr + wl - (wl > 0 ? wl : 0));
            ptr = reg_addr_o;
            bus_start();
            write_byte({exp_addr(k), 1'b1}, ack);
            check(ack, "R5 read address ack", ack, 1);
            for (int j = 0; j < rl; j++) begin
                read_byte(j != rl - 1, v);
                check(v == exp_mem[8'(ptr + j)], "R5 read byte", v, exp_mem[8'(ptr + j)]);
            end
            bus_stop();
            check(reg_addr_o == 8'(ptr + rl - 1), "R8 pointer kept after read",
                  reg_addr_o, 8'(ptr + rl - 1));
        end

        check(high_changes == 0, "R10 pull changed with SCL high", high_changes, 0);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule